// File: doc/BRIEF.md
# PCI Burst Time-Slice Limiter

This block caps how long a PCI initiator may keep a burst going once other agents want the bus. Software writes an 8-bit latency value into a configuration register. Only the upper nibble can be set, so the slice is a multiple of 16 PCI clocks. While the initiator holds FRAME# asserted, the block counts PCI clocks. When the count reaches the programmed slice, the count has expired. The block then raises a terminate request for the master state machine, but it waits until the hold-acknowledge input has gone inactive.

A burst that finishes first, signalled by a single-cycle transaction-done strobe, never produces a terminate request. When FRAME# is released, the counter, the expired state and the request all return to idle, so each burst starts a fresh slice. As long as hold-acknowledge stays active, the burst may run on indefinitely past expiry.

Top module: `pci_burst_slice_limiter`

## Requirements
- R1: After a synchronous reset, the register reads 00h and `term_req` is low.
- R2: Bits [3:0] of the register always read as zero. Write data in those bits is discarded, so the slice is L = 16 × bits [7:4] clocks.
- R3: A write with `cfg_be0` low leaves the register unchanged. A write with `cfg_be0` high stores bits [7:4] of `cfg_wdata`.
- R4: While `frame_act` is low, `term_req` stays low and the count is held at zero. Every burst measures its slice from its own first clock.
- R5: With hold-acknowledge low and no done strobe, `term_req` is first seen high after the (L+1)-th rising edge at which `frame_act` is high.
- R6: While `hold_ack` is high, `term_req` does not rise. If `hold_ack` is first sampled low at edge m ≥ L, with edges counted from 0, `term_req` is high after edge m.
- R7: A `xfer_done` strobe sampled at or before the edge that would raise `term_req` suppresses the request for the rest of that burst.
- R8: Once raised, `term_req` stays high while `frame_act` stays high, even through a later done strobe. It is low after the first edge at which `frame_act` is low.
- R9: A slice of 0 expires on the first clock of a burst, so `term_req` rises after edge 0 when `hold_ack` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be0 | input | 1 | Byte enable for the register byte |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Current register value |
| frame_act | input | 1 | This master is asserting FRAME# |
| hold_ack | input | 1 | Hold-acknowledge level, active high |
| xfer_done | input | 1 | Transaction-done strobe |
| term_req | output | 1 | Registered terminate request to the master sequencer |

## Verification
Every upper-nibble value from 0 to 15 is run as a burst with hold-acknowledge low. This places the expiry edge at every possible slice, including the zero slice. Bursts with a fixed slice are then run with hold-acknowledge released before, exactly at and after expiry. These runs separate gating by the count from gating by hold-acknowledge. Done strobes are placed before expiry, on the expiry edge and after the request. Those cases show suppression, the tie between done and expiry, and the stickiness of the request. Back-to-back bursts and idle stretches show that the count restarts with each burst.

// File: rtl/mlt_pkg.sv
package mlt_pkg;

    parameter int MLT_REG_W   = 8;
    parameter int MLT_RSVD_W  = 4;
    localparam int MLT_CNT_W  = MLT_REG_W;

    typedef struct packed {
        logic done_seen;
        logic term;
    } term_state_t;

    function automatic logic [MLT_REG_W-1:0] prog_mask();
        logic [MLT_REG_W-1:0] m;
        m = '1;
        m[MLT_RSVD_W-1:0] = '0;
        return m;
    endfunction

    function automatic logic [MLT_CNT_W-1:0] slice_of(input logic [MLT_REG_W-1:0] r);
        return MLT_CNT_W'(r & prog_mask());
    endfunction

endpackage

// File: rtl/mlt_cfg_reg.sv
module mlt_cfg_reg
    import mlt_pkg::*;
#(
    parameter int REG_W = MLT_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic             be0,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] rdata,
    output logic [REG_W-1:0] limit
);
    logic [REG_W-1:0] value_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            value_q <= '0;
        end else if (wr && be0) begin
            value_q <= wdata & REG_W'(prog_mask());
        end
    end

    assign rdata = value_q;
    assign limit = REG_W'(slice_of(MLT_REG_W'(value_q)));
endmodule

// File: rtl/mlt_slice_counter.sv
module mlt_slice_counter #(
    parameter int CNT_W = mlt_pkg::MLT_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_act,
    input  logic [CNT_W-1:0] limit,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;
    logic             exp_q;
    logic             reached;

    assign reached = (cnt_q >= limit);
    assign expired = exp_q || reached;

    always_ff @(posedge clk) begin
        if (rst || !frame_act) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            if (!reached) begin
                cnt_q <= cnt_q + 1'b1;
            end
            exp_q <= expired;
        end
    end
endmodule

// File: rtl/mlt_term_ctrl.sv
module mlt_term_ctrl
    import mlt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic frame_act,
    input  logic hold_ack,
    input  logic xfer_done,
    input  logic expired,
    output logic term_req
);
    term_state_t st_q, st_d;
    logic        done_any;

    always_comb begin
        done_any     = xfer_done || st_q.done_seen;
        st_d         = '0;
        if (frame_act) begin
            st_d.done_seen = done_any;
            st_d.term      = st_q.term || (!done_any && expired && !hold_ack);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign term_req = st_q.term;
endmodule

// File: rtl/pci_burst_slice_limiter.sv
module pci_burst_slice_limiter
    import mlt_pkg::*;
#(
    parameter int REG_W = MLT_REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic             cfg_be0,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             frame_act,
    input  logic             hold_ack,
    input  logic             xfer_done,
    output logic             term_req
);
    localparam int CNT_W = REG_W;

    logic [CNT_W-1:0] limit;
    logic             expired;

    mlt_cfg_reg #(.REG_W(REG_W)) u_cfg (
        .clk   (clk),
        .rst   (rst),
        .wr    (cfg_wr),
        .be0   (cfg_be0),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .limit (limit)
    );

    mlt_slice_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .limit     (limit),
        .expired   (expired)
    );

    mlt_term_ctrl u_term (
        .clk       (clk),
        .rst       (rst),
        .frame_act (frame_act),
        .hold_ack  (hold_ack),
        .xfer_done (xfer_done),
        .expired   (expired),
        .term_req  (term_req)
    );
endmodule

// File: rtl/mlt_checker.sv
module mlt_checker #(
    parameter int REG_W = mlt_pkg::MLT_REG_W
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_wr,
    input logic             cfg_be0,
    input logic [REG_W-1:0] cfg_rdata,
    input logic             frame_act,
    input logic             hold_ack,
    input logic             xfer_done,
    input logic             term_req
);
    localparam int RSVD_W = mlt_pkg::MLT_RSVD_W;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        cfg_rdata[RSVD_W-1:0] == '0); // R2

    AST_BE_GATED: assert property (@(posedge clk) disable iff (rst)
        !(cfg_wr && cfg_be0) |=> $stable(cfg_rdata)); // R3

    AST_IDLE_NO_TERM: assert property (@(posedge clk) disable iff (rst)
        !frame_act |=> !term_req); // R4

    AST_HOLD_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!term_req && hold_ack) |=> !term_req); // R6

    AST_DONE_BLOCKS: assert property (@(posedge clk) disable iff (rst)
        (!term_req && xfer_done) |=> !term_req); // R7

    AST_TERM_STICKY: assert property (@(posedge clk) disable iff (rst)
        (term_req && frame_act) |=> term_req); // R8
endmodule

bind pci_burst_slice_limiter mlt_checker #(.REG_W(REG_W)) u_mlt_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_be0   (cfg_be0),
    .cfg_rdata (cfg_rdata),
    .frame_act (frame_act),
    .hold_ack  (hold_ack),
    .xfer_done (xfer_done),
    .term_req  (term_req)
);

// File: tb/pci_burst_slice_limiter_bench.sv
module pci_burst_slice_limiter_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic       cfg_wr, cfg_be0;
    logic [7:0] cfg_wdata, cfg_rdata;
    logic       frame_act, hold_ack, xfer_done;
    logic       term_req;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    pci_burst_slice_limiter u_pci_burst_slice_limiter (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be0(cfg_be0),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .frame_act(frame_act),
        .hold_ack(hold_ack), .xfer_done(xfer_done), .term_req(term_req)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic be, input logic [7:0] d);
        cfg_wr = 1'b1; cfg_be0 = be; cfg_wdata = d;
        @(posedge clk); #1;
        cfg_wr = 1'b0; cfg_be0 = 1'b0;
    endtask

    // Runs a burst with slice nib*16; hold high for edges k < hold_rel,
    // done strobe at edge done_at. Expected rise edge T = max(L, hold_rel).
    task automatic burst(input string req, input int nib, input int hold_rel, input int done_at);
        int lim, t, n_end, bad_k, bad_a, bad_e;
        bit supp;
        lim  = nib * 16;
        t    = (lim > hold_rel) ? lim : hold_rel;
        supp = (done_at <= t);
        n_end = t + 3;
        bad_k = -1; bad_a = 0; bad_e = 0;
        cfg_write(1'b1, 8'(nib << 4));
        for (int k = 0; k <= n_end; k++) begin
            frame_act = 1'b1;
            hold_ack  = (k < hold_rel);
            xfer_done = (k == done_at);
            @(posedge clk); #1;
            if (bad_k < 0 && int'(term_req) != int'(k >= t && !supp)) begin
                bad_k = k; bad_a = int'(term_req); bad_e = int'(k >= t && !supp);
            end
        end
        if (bad_k >= 0) $display("  mismatch at edge %0d (L=%0d)", bad_k, lim);
        check(req, bad_a, bad_e);
        frame_act = 1'b0; hold_ack = 1'b0; xfer_done = 1'b0;
        @(posedge clk); #1;
        check("R8 clear after FRAME release", int'(term_req), 0);
    endtask

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_be0 = 1'b0; cfg_wdata = 8'h00;
        frame_act = 1'b0; hold_ack = 1'b0; xfer_done = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        check("R1 reset reg", int'(cfg_rdata), 0);
        check("R1 reset term", int'(term_req), 0);

        cfg_write(1'b1, 8'hA5);
        check("R2 low nibble dropped", int'(cfg_rdata), 'hA0);
        cfg_write(1'b0, 8'h3C);
        check("R3 be0 low ignored", int'(cfg_rdata), 'hA0);
        cfg_write(1'b1, 8'h3C);
        check("R3 be0 high stores", int'(cfg_rdata), 'h30);

        // R4: idle with slice 0 and hold low never requests
        cfg_write(1'b1, 8'h00);
        repeat (5) @(posedge clk);
        #1 check("R4 idle no term", int'(term_req), 0);

        // R5 / R9: sweep every slice value, back to back (also R4 restart)
        for (int nib = 0; nib < 16; nib++)
            burst(nib == 0 ? "R9 zero slice" : "R5 slice sweep", nib, 0, 10000);

        // R6: hold release before, at and after expiry
        burst("R6 hold early",   1, 5,  10000);
        burst("R6 hold at L",    1, 16, 10000);
        burst("R6 hold late",    1, 17, 10000);
        burst("R6 hold long",    1, 60, 10000);
        burst("R6 hold zero sl", 0, 7,  10000);

        // R7 / R8: done strobe placement
        burst("R7 done early",   2, 0, 10);
        burst("R7 done on edge", 2, 0, 32);
        burst("R7 done held",    2, 40, 20);
        burst("R8 done after",   2, 0, 33);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule